// File: doc/BRIEF.md
# RMII Receive-Side Dibit Driver

This block sits on the PHY side of a reduced media-independent interface and produces the receive signals seen by the MAC: the combined carrier/data-valid line and the two-bit receive data bus. It takes received bytes from a show-ahead FIFO through a valid/ready handshake. Each byte goes out as dibits, least significant pair first, and every output is registered on the reference clock.

When carrier appears, the driver raises carrier/data-valid and holds the data bus at 00 until a byte is available. If carrier ends while bytes remain buffered, the valid line alternates on dibit boundaries: low on the first dibit of each nibble and high on the second. This lets the MAC tell that carrier has gone but data is still arriving. A false carrier detected at carrier onset, or a symbol error during reception, replaces the data with the code 10 for as long as carrier lasts, and the rest of the buffered frame is discarded. A speed input selects one clock per dibit or a slow pace that holds each dibit for `SLOW_DIV` clocks.

Top module: `rmii_rxd_driver`

## Requirements
- R1: During and right after reset, crs_dv is 0, rxd is 00 and fifo_ready is 0.
- R2: A carrier rise with false_carrier low gives crs_dv = 1 and rxd = 00 on the next edge. These values hold while no byte is available.
- R3: A byte seen valid goes out as four dibits: bits [1:0] first, then [3:2], [5:4] and [7:6]. The first dibit appears on the edge after the byte is seen. A leading preamble byte 0x55 therefore shows the start code 01 as its first dibit.
- R4: With speed_10 = 0 each dibit lasts one clock. With speed_10 = 1 each dibit lasts SLOW_DIV (default 10) clocks, and rxd and crs_dv change only at dibit boundaries.
- R5: A byte is released by fifo_ready on the same edge that loads its last dibit onto rxd, never earlier.
- R6: At each dibit start, crs_dv is 1 if carrier is high. If carrier is low, crs_dv is 0 for dibit positions 0 and 2 and 1 for positions 1 and 3.
- R7: When the last dibit ends and the FIFO is empty, the next edge drives rxd = 00. crs_dv goes to 0 if carrier is low, or stays at 1 (waiting) if carrier is high.
- R8: A carrier rise with false_carrier high gives crs_dv = 1 and rxd = 10 for as long as carrier lasts. After carrier drops, both return to 0 on the next edge.
- R9: A symbol_err pulse while waiting or sending gives rxd = 10 and crs_dv = 1 from the next edge while carrier stays high. Buffered bytes are discarded. Once carrier is low and the FIFO is empty, the outputs return to 0.
- R10: With carrier low in idle, FIFO contents and symbol_err have no effect: the outputs stay 0 and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_10 | input | 1 | 1 selects slow pacing (SLOW_DIV clocks per dibit) |
| carrier | input | 1 | Carrier-sense level from the line decoder |
| false_carrier | input | 1 | Carrier onset was a false carrier |
| symbol_err | input | 1 | Symbol error seen during reception |
| fifo_data | input | BYTE_W | Head byte of the receive FIFO |
| fifo_valid | input | 1 | FIFO head is valid |
| fifo_ready | output | 1 | Pops the FIFO head |
| crs_dv | output | 1 | Carrier sense / data valid toward the MAC |
| rxd | output | 2 | Receive dibit toward the MAC |

## Verification
The bench sweeps both speeds, frames of one to three bytes, and carrier loss at the first edge, at the second edge, mid-frame (including mid-dibit at slow pace) and after the frame. Every cycle is compared against dibit and pop positions computed arithmetically. A driver that sent the most significant dibit first, or popped a byte before its last dibit, would corrupt the data or the pop count. One whose valid line toggled in the wrong phase, or changed inside a slow dibit, would break the carrier-loss cases. Separate runs cover idle with stale FIFO data, a false carrier that must also drain the FIFO, and a symbol error mid-frame followed by a clean frame. A driver that left the error state early or kept stale bytes would fail the recovery frame.

// File: rtl/rmii_rxd_pkg.sv
package rmii_rxd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DATA = 2'd2,
      ST_BAD  = 2'd3
   } rx_state_e;

   localparam logic [1:0] DIBIT_QUIET = 2'b00;
   localparam logic [1:0] DIBIT_ERR   = 2'b10;
endpackage

// File: rtl/rmii_rxd_pace.sv
module rmii_rxd_pace #(
   parameter int SLOW_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow,
   input  logic restart,
   output logic tick
);
   localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

   generate
      if (SLOW_DIV < 2) begin : g_bad_div
         $error("rmii_rxd_pace: SLOW_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = !slow || (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart || tick) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rmii_rxd_dibit_sel.sv
module rmii_rxd_dibit_sel #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0]                 byte_i,
   input  logic [$clog2(BYTE_W/2)-1:0]       idx_i,
   output logic [1:0]                        dibit_o
);
   localparam int DIBITS = BYTE_W / 2;

   generate
      if (BYTE_W < 4 || (BYTE_W % 2) != 0 || (DIBITS & (DIBITS - 1)) != 0) begin : g_bad_w
         $error("rmii_rxd_dibit_sel: BYTE_W must be even, at least 4, with a power-of-two dibit count");
      end
   endgenerate

   logic [1:0] pairs [DIBITS];

   for (genvar g = 0; g < DIBITS; g++) begin : g_pair
      assign pairs[g] = byte_i[2*g +: 2];
   end

   assign dibit_o = pairs[idx_i];
endmodule

// File: rtl/rmii_rxd_driver.sv
module rmii_rxd_driver
   import rmii_rxd_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int SLOW_DIV = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              speed_10,
   input  logic              carrier,
   input  logic              false_carrier,
   input  logic              symbol_err,
   input  logic [BYTE_W-1:0] fifo_data,
   input  logic              fifo_valid,
   output logic              fifo_ready,
   output logic              crs_dv,
   output logic [1:0]        rxd
);
   localparam int DIBITS = BYTE_W / 2;
   localparam int IW     = $clog2(DIBITS);
   localparam logic [IW-1:0] LAST_IDX = IW'(DIBITS - 1);
   localparam logic [IW-1:0] PRE_IDX  = IW'(DIBITS - 2);

   rx_state_e     st_q, st_d;
   logic [IW-1:0] idx_q, idx_d, idx_sel;
   logic          dv_q, dv_d;
   logic [1:0]    rxd_q, rxd_d;
   logic [1:0]    sel_dibit;
   logic          pace_tick;

   rmii_rxd_pace #(.SLOW_DIV(SLOW_DIV)) u_pace (
      .clk     (clk),
      .rst_n   (rst_n),
      .slow    (speed_10),
      .restart (st_q != ST_DATA),
      .tick    (pace_tick)
   );

   assign idx_sel = (st_q == ST_DATA && idx_q != LAST_IDX) ? idx_q + 1'b1 : '0;

   rmii_rxd_dibit_sel #(.BYTE_W(BYTE_W)) u_sel (
      .byte_i  (fifo_data),
      .idx_i   (idx_sel),
      .dibit_o (sel_dibit)
   );

   always_comb begin
      st_d       = st_q;
      idx_d      = idx_q;
      dv_d       = dv_q;
      rxd_d      = rxd_q;
      fifo_ready = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (carrier) begin
               dv_d = 1'b1;
               if (false_carrier) begin
                  st_d  = ST_BAD;
                  rxd_d = DIBIT_ERR;
               end else begin
                  st_d  = ST_WAIT;
                  rxd_d = DIBIT_QUIET;
               end
            end
         end
         ST_WAIT: begin
            if (symbol_err) begin
               st_d  = ST_BAD;
               dv_d  = carrier;
               rxd_d = carrier ? DIBIT_ERR : DIBIT_QUIET;
            end else if (fifo_valid) begin
               st_d  = ST_DATA;
               idx_d = '0;
               dv_d  = carrier;
               rxd_d = sel_dibit;
            end else if (!carrier) begin
               st_d  = ST_IDLE;
               dv_d  = 1'b0;
               rxd_d = DIBIT_QUIET;
            end
         end
         ST_DATA: begin
            if (symbol_err) begin
               st_d  = ST_BAD;
               dv_d  = carrier;
               rxd_d = carrier ? DIBIT_ERR : DIBIT_QUIET;
            end else if (pace_tick) begin
               if (idx_q != LAST_IDX) begin
                  idx_d      = idx_sel;
                  dv_d       = carrier | idx_sel[0];
                  rxd_d      = sel_dibit;
                  fifo_ready = (idx_q == PRE_IDX);
               end else if (fifo_valid) begin
                  idx_d = '0;
                  dv_d  = carrier;
                  rxd_d = sel_dibit;
               end else begin
                  st_d  = carrier ? ST_WAIT : ST_IDLE;
                  dv_d  = carrier;
                  rxd_d = DIBIT_QUIET;
               end
            end
         end
         ST_BAD: begin
            fifo_ready = 1'b1;
            dv_d       = carrier;
            rxd_d      = carrier ? DIBIT_ERR : DIBIT_QUIET;
            if (!carrier && !fifo_valid) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         dv_q  <= 1'b0;
         rxd_q <= DIBIT_QUIET;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         dv_q  <= dv_d;
         rxd_q <= rxd_d;
      end
   end

   assign crs_dv = dv_q;
   assign rxd    = rxd_q;
endmodule

// File: rtl/rmii_rxd_driver_chk.sv
module rmii_rxd_driver_chk
   import rmii_rxd_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          carrier,
   input logic                          false_carrier,
   input logic                          symbol_err,
   input logic                          fifo_valid,
   input logic                          fifo_ready,
   input logic [1:0]                    fifo_top,
   input logic                          crs_dv,
   input logic [1:0]                    rxd,
   input rx_state_e                     st,
   input logic [$clog2(BYTE_W/2)-1:0]   idx,
   input logic                          tick
);
   p_quiet_reset_r1: assert property (@(posedge clk)
      !rst_n |=> !crs_dv && rxd == 2'b00);

   p_wait_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_WAIT && carrier && !symbol_err && !fifo_valid |=> crs_dv && rxd == 2'b00);

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_DATA && !tick && !symbol_err |=> $stable(rxd) && $stable(crs_dv));

   p_pop_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_DATA && fifo_ready && fifo_valid |=> rxd == $past(fifo_top));

   p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_DATA && tick && !carrier && !symbol_err && idx == '0 |=> crs_dv);

   p_false_carrier_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_IDLE && carrier && false_carrier |=> crs_dv && rxd == 2'b10);

   p_sym_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT || st == ST_DATA) && symbol_err && carrier |=> crs_dv && rxd == 2'b10);

   p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_IDLE && !carrier |=> !crs_dv && rxd == 2'b00 && !$past(fifo_ready));
endmodule

bind rmii_rxd_driver rmii_rxd_driver_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .carrier       (carrier),
   .false_carrier (false_carrier),
   .symbol_err    (symbol_err),
   .fifo_valid    (fifo_valid),
   .fifo_ready    (fifo_ready),
   .fifo_top      (fifo_data[BYTE_W-1 -: 2]),
   .crs_dv        (crs_dv),
   .rxd           (rxd),
   .st            (st_q),
   .idx           (idx_q),
   .tick          (pace_tick)
);

// File: tb/test_rmii_rxd_driver.sv
`timescale 1ns/1ps
module test_rmii_rxd_driver;
   localparam int CLK_PERIOD = 10;
   localparam int SLOW = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       speed_10 = 1'b0;
   logic       carrier = 1'b0;
   logic       false_carrier = 1'b0;
   logic       symbol_err = 1'b0;
   logic [7:0] fifo_data;
   logic       fifo_valid;
   logic       fifo_ready;
   logic       crs_dv;
   logic [1:0] rxd;

   logic [7:0] mem [256];
   logic [7:0] wr_p = 8'd0;
   logic [7:0] rd_p;
   logic [7:0] cnt;

   int n_checks = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign fifo_valid = (wr_p != rd_p);
   assign fifo_data  = mem[rd_p];
   assign cnt        = wr_p - rd_p;

   always @(posedge clk) begin
      if (!rst_n) rd_p <= 8'd0;
      else if (fifo_ready && fifo_valid) rd_p <= rd_p + 8'd1;
   end

   rmii_rxd_driver #(.BYTE_W(8), .SLOW_DIV(SLOW)) i_rmii_rxd_driver (
      .clk(clk), .rst_n(rst_n), .speed_10(speed_10), .carrier(carrier),
      .false_carrier(false_carrier), .symbol_err(symbol_err),
      .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
      .crs_dv(crs_dv), .rxd(rxd)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [7:0] b);
      mem[wr_p] = b;
      wr_p = wr_p + 8'd1;
   endtask

   task automatic run_frame(input bit slow, input int n, input int e_drop);
      int h;
      int tot;
      logic [7:0] bytes [4];
      h = slow ? SLOW : 1;
      tot = 4 * n * h;
      speed_10 = slow;
      carrier = 1'b1;
      step();
      for (int w = 0; w < 3; w++) begin
         check("R2 wait dv", int'(crs_dv), 1);
         check("R2 wait rxd", int'(rxd), 0);
         step();
      end
      for (int i = 0; i < n; i++) begin
         bytes[i] = (i == 0) ? 8'h55 : 8'((i * 37 + n * 11 + int'(slow) * 5 + e_drop) & 255);
         push(bytes[i]);
      end
      for (int k = 0; k <= tot; k++) begin
         int j, popped;
         carrier = (k < e_drop);
         step();
         popped = 0;
         for (int b = 0; b < n; b++) if ((4 * b + 3) * h <= k) popped++;
         check("R5 fifo level", int'(cnt), n - popped);
         if (k < tot) begin
            j = k / h;
            check("R3/R4 rxd dibit", int'(rxd), int'((bytes[j / 4] >> (2 * (j % 4))) & 8'd3));
            check("R6 crs_dv phase", int'(crs_dv), (j * h < e_drop) ? 1 : (j % 2));
            if (k == 0) check("R3 start code", int'(rxd), 1);
         end else begin
            check("R7 end rxd", int'(rxd), 0);
            check("R7 end dv", int'(crs_dv), (k < e_drop) ? 1 : 0);
         end
      end
      if (carrier) begin
         carrier = 1'b0;
         step();
         check("R7 idle dv", int'(crs_dv), 0);
         check("R7 idle rxd", int'(rxd), 0);
      end
      step();
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) step();
      check("R1 reset dv", int'(crs_dv), 0);
      check("R1 reset rxd", int'(rxd), 0);
      check("R1 reset ready", int'(fifo_ready), 0);
      rst_n = 1'b1;
      step();
      check("R1 after reset dv", int'(crs_dv), 0);

      // R10: stale data and error pulse with no carrier
      push(8'hA7);
      push(8'h3C);
      symbol_err = 1'b1;
      step();
      symbol_err = 1'b0;
      repeat (4) step();
      check("R10 idle dv", int'(crs_dv), 0);
      check("R10 idle rxd", int'(rxd), 0);
      check("R10 no pop", int'(cnt), 2);

      // R8: false carrier, also flushes the stale bytes
      carrier = 1'b1;
      false_carrier = 1'b1;
      step();
      false_carrier = 1'b0;
      for (int c = 0; c < 8; c++) begin
         check("R8 false dv", int'(crs_dv), 1);
         check("R8 false rxd", int'(rxd), 2);
         step();
      end
      check("R9 discard on error", int'(cnt), 0);
      carrier = 1'b0;
      step();
      check("R8 drop dv", int'(crs_dv), 0);
      check("R8 drop rxd", int'(rxd), 0);
      step();

      // R3 R4 R5 R6 R7 sweep
      for (int s = 0; s < 2; s++) begin
         for (int n = 1; n <= 3; n++) begin
            for (int d = 0; d < 4; d++) begin
               int h, e;
               h = (s != 0) ? SLOW : 1;
               case (d)
                  0: e = 0;
                  1: e = 1;
                  2: e = (4 * n * h) / 2 + 1;
                  default: e = 4 * n * h + 1;
               endcase
               run_frame(s != 0, n, e);
            end
         end
      end

      // R9: symbol error mid-frame, then recovery
      speed_10 = 1'b0;
      carrier = 1'b1;
      step();
      push(8'h55);
      push(8'hD5);
      push(8'h12);
      step();
      step();
      symbol_err = 1'b1;
      step();
      symbol_err = 1'b0;
      check("R9 err rxd", int'(rxd), 2);
      check("R9 err dv", int'(crs_dv), 1);
      for (int c = 0; c < 5; c++) step();
      check("R9 err hold rxd", int'(rxd), 2);
      check("R9 err flushed", int'(cnt), 0);
      carrier = 1'b0;
      step();
      check("R9 end dv", int'(crs_dv), 0);
      check("R9 end rxd", int'(rxd), 0);
      step();
      run_frame(1'b0, 2, 3);
      run_frame(1'b1, 1, 15);

      finish_up();
   end
endmodule